// File: doc/BRIEF.md
# Temperature Window Event Comparator

This block watches a stream of signed temperature samples, each a two's-complement code worth 0.25 °C per LSB. It holds three trip flags: above the alarm window, below the alarm window, and at or over a critical limit. Each flag sets at one threshold and clears at another. The distance between the two is a selectable hysteresis that is subtracted from the programmed bound, and the subtraction saturates at the most negative code.

The three flags and a set of configuration controls drive one event output:

- **Mode:** comparator or interrupt.
- **Polarity:** active-low or active-high.
- **Output enable.**
- **Critical-only:** only the critical flag drives the event.
- **Clear-event strobe.**
- **Shutdown.**

In interrupt mode, every entry into or exit from the alarm window latches an event, and the event stays asserted until software pulses clear-event. The critical flag always acts as a comparator, and clear-event cannot remove it. Shutdown freezes the flags and the event state.

The block sits between a converter, which supplies the samples and a valid strobe, and a register file, which supplies the thresholds and controls.

Top module: `temp_event_cmp`

## Requirements
- R1: After reset all three flags and the event status are 0. The event output is at its deasserted level, which is 1 when active-high is 0 and 0 when active-high is 1.
- R2: The above flag sets on an accepted sample strictly greater than the upper bound. Once set, it clears on an accepted sample less than or equal to the upper bound minus the hysteresis.
- R3: The below flag sets on an accepted sample strictly less than the lower bound minus the hysteresis. Once set, it clears on an accepted sample greater than or equal to the lower bound.
- R4: The critical flag sets on an accepted sample greater than or equal to the critical limit. Once set, it clears on an accepted sample strictly less than the critical limit minus the hysteresis.
- R5: The hysteresis select encodes 2'b00 = 0 LSB, 2'b01 = 6 LSB, 2'b10 = 12 LSB and 2'b11 = 24 LSB.
- R6: All comparisons are signed on the 11-bit code. A bound minus hysteresis that would fall below -1024 saturates to -1024 and does not wrap.
- R7: Flags change only at a clock edge where the sample strobe is 1 and shutdown is 0. Otherwise the flags hold, and the event state holds as well, except for a clear-event pulse.
- R8: In interrupt mode, each change of the window-out state (above OR below) asserts the event in the same cycle the flag changes. The event stays latched until a cycle with clear-event = 1. A window change in the same cycle as a clear wins over the clear.
- R9: While the critical flag is 1, the event status is 1 in either mode, and clear-event does not deassert it.
- R10: With critical-only = 1, the alarm window does not drive the event and only the critical flag does. With critical-only = 0, both do. In comparator mode the alarm term is above OR below.
- R11: With enable = 0 the event output sits at its deasserted level while the event status still reports the condition. With enable = 1 the output equals the status when active-high = 1 and its inverse when active-high = 0.
- R12: The trip flags depend only on samples and thresholds. Enable, mode, polarity, critical-only and clear-event never change them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | A new sample is present this cycle |
| smp_temp | input | 11 | Sample, signed, 0.25 °C per LSB |
| thr_upper | input | 11 | Alarm window upper bound, signed |
| thr_lower | input | 11 | Alarm window lower bound, signed |
| thr_crit | input | 11 | Critical limit, signed |
| cfg_hys | input | 2 | Hysteresis select |
| cfg_irq_mode | input | 1 | 1 = interrupt mode, 0 = comparator mode |
| cfg_act_high | input | 1 | 1 = active-high event output |
| cfg_out_en | input | 1 | Event output enable |
| cfg_crit_only | input | 1 | Only the critical flag drives the event |
| cfg_shutdown | input | 1 | Freeze sampling and event state |
| clr_evt | input | 1 | Clear-event strobe |
| flag_above | output | 1 | Above-window flag |
| flag_below | output | 1 | Below-window flag |
| flag_crit | output | 1 | Critical flag |
| evt_status | output | 1 | Event condition, independent of enable and polarity |
| evt_out | output | 1 | Event output level |

## Verification
The bench targets the edges of each hysteresis band for all four select codes. A design that cleared at the wrong side of a bound, or that used one threshold for both set and clear, would flip a flag one LSB early or late.

Bounds near -1024 with 24 LSB of hysteresis expose a wrapping subtraction: the lowered threshold would jump to a large positive value and set the below flag falsely.

Interrupt scenarios check three things:
- a clear pulse removes a latched window event;
- a clear pulse leaves a critical event standing;
- a shutdown or an invalid strobe freezes every flag even when the sample is extreme.

A design that gated flags with enable, or let clear override critical, would show the wrong status.

// File: rtl/temp_evt_pkg.sv
package temp_evt_pkg;

    typedef struct packed {
        logic above;
        logic below;
        logic crit;
    } trip_flags_t;

    typedef struct packed {
        logic irq;
        logic win_prev;
    } evt_state_t;

    // Hysteresis select to LSB count (0.25 C per LSB): 0, 1.5, 3, 6 C
    function automatic int unsigned hys_lsb(input logic [1:0] sel);
        case (sel)
            2'b01:   return 6;
            2'b10:   return 12;
            2'b11:   return 24;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/temp_hys_sub.sv
module temp_hys_sub #(
    parameter int W = 11
) (
    input  logic signed [W-1:0] base,
    input  logic        [1:0]   sel,
    output logic signed [W-1:0] lowered
);
    import temp_evt_pkg::*;

    localparam logic signed [W:0] MIN_EXT = {2'b11, {(W-1){1'b0}}};
    localparam logic signed [W-1:0] MIN_CODE = {1'b1, {(W-1){1'b0}}};

    logic signed [W:0] base_ext;
    logic signed [W:0] hys_ext;
    logic signed [W:0] diff;

    always_comb begin
        base_ext = {base[W-1], base};
        hys_ext  = (W+1)'(hys_lsb(sel));
        diff     = base_ext - hys_ext;
        if (diff < MIN_EXT) lowered = MIN_CODE;
        else                lowered = diff[W-1:0];
    end

    // R6
    sat_no_wrap_chk: assert final (lowered <= base);
endmodule

// File: rtl/temp_trip_flags.sv
module temp_trip_flags #(
    parameter int W = 11
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     upd,
    input  logic signed [W-1:0]      t,
    input  logic signed [W-1:0]      hi,
    input  logic signed [W-1:0]      lo,
    input  logic signed [W-1:0]      crit,
    input  logic signed [W-1:0]      hi_h,
    input  logic signed [W-1:0]      lo_h,
    input  logic signed [W-1:0]      crit_h,
    output temp_evt_pkg::trip_flags_t flags_q
);
    import temp_evt_pkg::*;

    trip_flags_t flags_d;

    always_comb begin
        flags_d = flags_q;
        if (upd) begin
            if (!flags_q.above) flags_d.above = (t > hi);
            else                flags_d.above = (t > hi_h);
            if (!flags_q.below) flags_d.below = (t < lo_h);
            else                flags_d.below = (t < lo);
            if (!flags_q.crit)  flags_d.crit  = (t >= crit);
            else                flags_d.crit  = (t >= crit_h);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    // R7
    hold_without_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> $stable(flags_q));
    // R2
    above_set_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && !flags_q.above && t <= hi) |=> !flags_q.above);
    // R4
    crit_set_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && !flags_q.crit && t < crit) |=> !flags_q.crit);
    // R3
    below_clear_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && flags_q.below && t >= lo) |=> !flags_q.below);
endmodule

// File: rtl/temp_evt_drive.sv
module temp_evt_drive (
    input  logic                     clk,
    input  logic                     rst_n,
    input  temp_evt_pkg::trip_flags_t flags,
    input  logic                     irq_mode,
    input  logic                     act_high,
    input  logic                     out_en,
    input  logic                     crit_only,
    input  logic                     shutdown,
    input  logic                     clr,
    output logic                     status,
    output logic                     level
);
    import temp_evt_pkg::*;

    evt_state_t st_q, st_d;
    logic win, win_chg, alarm_term;

    always_comb begin
        win        = flags.above | flags.below;
        win_chg    = irq_mode && !shutdown && (win != st_q.win_prev);
        st_d.win_prev = win;
        if (win_chg)  st_d.irq = 1'b1;
        else if (clr) st_d.irq = 1'b0;
        else          st_d.irq = st_q.irq;

        if (crit_only)     alarm_term = 1'b0;
        else if (irq_mode) alarm_term = st_q.irq | win_chg;
        else               alarm_term = win;

        status = flags.crit | alarm_term;
        level  = (out_en & status) ^ ~act_high;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R8
    irq_clears_only_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.irq) |-> $past(clr));
    // R9
    crit_forces_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flags.crit |-> status);
    // R11
    disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |-> (level == !act_high));
endmodule

// File: rtl/temp_event_cmp.sv
module temp_event_cmp #(
    parameter int TEMP_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic [TEMP_W-1:0] smp_temp,
    input  logic [TEMP_W-1:0] thr_upper,
    input  logic [TEMP_W-1:0] thr_lower,
    input  logic [TEMP_W-1:0] thr_crit,
    input  logic [1:0]        cfg_hys,
    input  logic              cfg_irq_mode,
    input  logic              cfg_act_high,
    input  logic              cfg_out_en,
    input  logic              cfg_crit_only,
    input  logic              cfg_shutdown,
    input  logic              clr_evt,
    output logic              flag_above,
    output logic              flag_below,
    output logic              flag_crit,
    output logic              evt_status,
    output logic              evt_out
);
    import temp_evt_pkg::*;

    localparam int NTHR = 3;

    logic signed [TEMP_W-1:0] thr_raw [NTHR];
    logic signed [TEMP_W-1:0] thr_low [NTHR];
    trip_flags_t              flags;
    logic                     upd;

    assign thr_raw[0] = $signed(thr_upper);
    assign thr_raw[1] = $signed(thr_lower);
    assign thr_raw[2] = $signed(thr_crit);
    assign upd        = smp_valid & ~cfg_shutdown;

    for (genvar k = 0; k < NTHR; k++) begin : g_hys
        temp_hys_sub #(.W(TEMP_W)) u_sub (
            .base    (thr_raw[k]),
            .sel     (cfg_hys),
            .lowered (thr_low[k])
        );
    end

    temp_trip_flags #(.W(TEMP_W)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .upd     (upd),
        .t       ($signed(smp_temp)),
        .hi      (thr_raw[0]),
        .lo      (thr_raw[1]),
        .crit    (thr_raw[2]),
        .hi_h    (thr_low[0]),
        .lo_h    (thr_low[1]),
        .crit_h  (thr_low[2]),
        .flags_q (flags)
    );

    temp_evt_drive u_drive (
        .clk       (clk),
        .rst_n     (rst_n),
        .flags     (flags),
        .irq_mode  (cfg_irq_mode),
        .act_high  (cfg_act_high),
        .out_en    (cfg_out_en),
        .crit_only (cfg_crit_only),
        .shutdown  (cfg_shutdown),
        .clr       (clr_evt),
        .status    (evt_status),
        .level     (evt_out)
    );

    assign flag_above = flags.above;
    assign flag_below = flags.below;
    assign flag_crit  = flags.crit;

    // R12
    flags_ignore_controls_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> ($stable(flag_above) && $stable(flag_below) && $stable(flag_crit)));
endmodule

// File: tb/temp_event_cmp_bench.sv
module temp_event_cmp_bench;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n;
    logic smp_valid, cfg_irq_mode, cfg_act_high, cfg_out_en, cfg_crit_only, cfg_shutdown, clr_evt;
    logic [10:0] smp_temp, thr_upper, thr_lower, thr_crit;
    logic [1:0] cfg_hys;
    logic flag_above, flag_below, flag_crit, evt_status, evt_out;

    temp_event_cmp u_temp_event_cmp (.*);

    int checks = 0, errors = 0;
    bit done = 0;
    bit m_above, m_below, m_crit, m_irq, m_prev;

    function automatic int hys_of(input logic [1:0] c);
        return (c == 2'b00) ? 0 : (c == 2'b01) ? 6 : (c == 2'b10) ? 12 : 24;
    endfunction

    function automatic int sat_sub(input int x, input int h);
        return (x - h < -1024) ? -1024 : x - h;
    endfunction

    function automatic int sv(input logic [10:0] v);
        return int'($signed(v));
    endfunction

    task automatic model_edge();
        int t, h;
        bit win, chg;
        t = sv(smp_temp);
        h = hys_of(cfg_hys);
        win = m_above | m_below;
        chg = cfg_irq_mode && !cfg_shutdown && (win != m_prev);
        if (chg) m_irq = 1;
        else if (clr_evt) m_irq = 0;
        m_prev = win;
        if (smp_valid && !cfg_shutdown) begin
            m_above = m_above ? (t > sat_sub(sv(thr_upper), h)) : (t > sv(thr_upper));
            m_below = m_below ? (t < sv(thr_lower)) : (t < sat_sub(sv(thr_lower), h));
            m_crit  = m_crit ? (t >= sat_sub(sv(thr_crit), h)) : (t >= sv(thr_crit));
        end
    endtask

    task automatic chk(input string tag, input string nm, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b", tag, nm, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        bit win, chg, alarm, st, lvl;
        win = m_above | m_below;
        chg = cfg_irq_mode && !cfg_shutdown && (win != m_prev);
        alarm = cfg_crit_only ? 0 : (cfg_irq_mode ? (m_irq | chg) : win);
        st = m_crit | alarm;
        lvl = cfg_act_high ? (cfg_out_en & st) : !(cfg_out_en & st);
        chk(tag, "above", flag_above, m_above);
        chk(tag, "below", flag_below, m_below);
        chk(tag, "crit", flag_crit, m_crit);
        chk(tag, "status", evt_status, st);
        chk(tag, "out", evt_out, lvl);
    endtask

    task automatic step(input bit v, input int t, input bit clr, input string tag);
        smp_valid = v; smp_temp = 11'(t); clr_evt = clr;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check_all(tag);
        smp_valid = 0; clr_evt = 0;
    endtask

    task automatic set_thr(input int hi, input int lo, input int cr, input logic [1:0] hs);
        thr_upper = 11'(hi); thr_lower = 11'(lo); thr_crit = 11'(cr); cfg_hys = hs;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int dummy;
        dummy = $urandom(32'd2024);
        rst_n = 0; smp_valid = 0; smp_temp = 0; clr_evt = 0;
        cfg_irq_mode = 0; cfg_act_high = 0; cfg_out_en = 1; cfg_crit_only = 0; cfg_shutdown = 0;
        set_thr(0, 0, 0, 2'b00);
        m_above = 0; m_below = 0; m_crit = 0; m_irq = 0; m_prev = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check_all("R1 reset");

        // R2 and R5: above flag band for every hysteresis code
        for (int c = 0; c < 4; c++) begin
            int h;
            h = hys_of(2'(c));
            set_thr(100, -200, 500, 2'(c));
            step(1, 100, 0, "R2");
            step(1, 101, 0, "R2 R5 set");
            step(1, 101 - h, 0, "R5 hold");
            step(1, 100 - h, 0, "R5 clear");
        end
        // R3
        set_thr(300, 0, 500, 2'b10);
        step(1, -12, 0, "R3 edge");
        step(1, -13, 0, "R3 set");
        step(1, -1, 0, "R3 hold");
        step(1, 0, 0, "R3 clear");
        // R4
        set_thr(100, -200, 200, 2'b11);
        step(1, 199, 0, "R4");
        step(1, 200, 0, "R4 set");
        step(1, 176, 0, "R4 hold");
        step(1, 175, 0, "R4 clear");
        // R6 saturation near the most negative code
        set_thr(-1024, -1020, 1000, 2'b11);
        step(1, -1024, 0, "R6 no below");
        step(1, -1023, 0, "R6 above set");
        step(1, -1024, 0, "R6 above clear");
        // R7 strobe and shutdown gating
        set_thr(100, -100, 300, 2'b00);
        step(1, 0, 0, "R7");
        step(0, 1000, 0, "R7 no strobe");
        cfg_shutdown = 1;
        step(1, 1000, 0, "R7 shutdown");
        step(1, -1000, 0, "R7 shutdown");
        cfg_shutdown = 0;
        // R8 interrupt latch
        cfg_irq_mode = 1;
        step(1, 0, 0, "R8");
        step(1, 101, 0, "R8 entry");
        step(1, 102, 0, "R8 latched");
        step(0, 0, 1, "R8 cleared");
        step(1, 50, 0, "R8 exit");
        step(1, 50, 1, "R8 cleared");
        step(1, 150, 1, "R8 change beats clear");
        step(0, 0, 1, "R8");
        // R9 critical ignores clear
        step(1, 310, 0, "R9 crit");
        step(0, 0, 1, "R9 clear ignored");
        step(0, 0, 1, "R9 clear ignored");
        // R10 critical only
        cfg_crit_only = 1;
        step(1, 50, 0, "R10");
        cfg_irq_mode = 0;
        step(1, 150, 0, "R10 window masked");
        cfg_crit_only = 0;
        step(0, 0, 0, "R10 window drives");
        // R11 enable and polarity; R12 flags unaffected
        cfg_out_en = 0;
        step(0, 0, 1, "R11 R12 disabled");
        cfg_act_high = 1;
        step(0, 0, 0, "R11 disabled high");
        cfg_out_en = 1;
        step(0, 0, 0, "R11 active high");

        // random phase
        for (int i = 0; i < 4000; i++) begin
            if (i % 25 == 0) begin
                int hi;
                hi = int'($urandom_range(0, 300)) - 100;
                set_thr(hi, hi - int'($urandom_range(0, 120)), hi + int'($urandom_range(0, 150)),
                        2'($urandom_range(0, 3)));
                cfg_irq_mode  = 1'($urandom);
                cfg_act_high  = 1'($urandom);
                cfg_out_en    = ($urandom_range(0, 3) != 0);
                cfg_crit_only = ($urandom_range(0, 4) == 0);
            end
            cfg_shutdown = ($urandom_range(0, 15) == 0);
            step(($urandom_range(0, 3) != 0),
                 ($urandom_range(0, 50) == 0) ? int'($urandom_range(0, 2047)) - 1024
                                              : int'($urandom_range(0, 500)) - 250,
                 ($urandom_range(0, 7) == 0), "R2 R3 R4 R7 R8 R9 R10 R11 R12 random");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule